// File: doc/BRIEF.md
# Interrupt Driveback Request Generator

This block watches a bank of interrupt lines and one system-management status line. When any of them changes level, it reports the new interrupt state to the host controller by mastering a single bus write. Each line passes through a two-flop synchronizer before its edges are detected. Any edge sets a pending flag. The system-management line counts only while its enable input is high.

The pending flag bids into a small fixed-priority arbiter. Several internal requesters share one active-low bus request pin through this arbiter. The driveback bid always ranks first. A requester that already holds the pin is never preempted, so the driveback cycle goes next, ahead of any other requester that is waiting. When the host answers with the active-low grant while the driveback logic owns the pin, the write master captures a snapshot of the synchronized levels. It then presents one write to the configured address and holds it until the host signals completion. Edges that arrive during a write re-arm the pending flag, so exactly one further write follows and no change is lost.

Top module: `dbk_top`

## Requirements
- R1: A rising or a falling transition on any `irq_i` line produces one driveback write. The transition is seen once it has passed the two synchronizer flops, and edges on several lines in the same cycle produce a single write.
- R2: A transition on `smi_i` produces a write only while `smi_en_i` is 1. With `smi_en_i` at 0, the transition is dropped and no request appears on the pin.
- R3: When the pin is idle and both a driveback bid and other requests are present, the driveback logic gets the pin. Among the other requesters, the lowest index wins.
- R4: An owner of the pin keeps it until its own done input is 1. A driveback bid that arrives during another requester's tenure is served right after it ends, ahead of the other waiting requesters.
- R5: `bus_req_no` is 0 exactly while some requester owns the pin. It goes to 1 on the cycle after the owner's done and stays at 1 for at least one cycle before the next tenure.
- R6: If `bus_gnt_ni` is sampled 0 while the driveback logic owns the pin, `wr_valid_o` rises on the next cycle, with `wr_addr_o` equal to `dbk_addr_i` as sampled at that edge. Valid, address and data hold until `wr_done_i` is sampled 1, and valid drops on the following cycle.
- R7: `wr_data_o` carries the synchronized `irq_i` levels in bits [15:0] and the synchronized `smi_i` level in bit 16, with bits [31:17] at 0. The snapshot is taken at the grant edge.
- R8: Edges that occur while a write is in flight lead to exactly one more write once the current one completes.
- R9: During reset, `bus_req_no` is 1 and `wr_valid_o` is 0. Input levels that are present when reset is released do not produce a write, because edges are masked for the first three cycles after release while the edge history fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | IRQ_W | Monitored interrupt levels (asynchronous) |
| smi_i | input | 1 | System-management status level (asynchronous) |
| smi_en_i | input | 1 | Allows `smi_i` transitions to trigger writes |
| dbk_addr_i | input | ADDR_W | Target address of the driveback write |
| oth_req_i | input | N_OTH | Bids from the other internal requesters |
| oth_done_i | input | N_OTH | End of tenure for each other requester |
| oth_own_o | output | N_OTH | One-hot ownership of the pin by the other requesters |
| bus_req_no | output | 1 | Shared bus request, active low |
| bus_gnt_ni | input | 1 | Bus grant from the host, active low |
| wr_valid_o | output | 1 | Driveback write presented |
| wr_addr_o | output | ADDR_W | Write address |
| wr_data_o | output | DATA_W | Write data (level snapshot) |
| wr_done_i | input | 1 | Host completes the write |

## Verification
The bench builds the block with sixteen interrupt lines, two other requesters and a 32-bit address and data path. With two other requesters the bench can reach both ordering cases: a driveback bid that has to wait behind a requester already holding the pin, and a driveback bid that beats a second requester queued at the same moment. A behavioural model in the bench predicts the request pin, the ownership outputs and the write on every cycle. The host's completion delay is varied so that edges land inside a write that is in flight.

// File: rtl/dbk_pkg.sv
package dbk_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_DBK  = 2'd1,
    ARB_OTH  = 2'd2
  } arb_state_e;

  // cycles after reset release before edges count
  localparam int unsigned WARM_CYC = 3;
endpackage

// File: rtl/dbk_edge_mon.sv
module dbk_edge_mon #(
  parameter int unsigned W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] lvl_o,
  output logic         chg_o
);
  import dbk_pkg::*;

  localparam int unsigned CW = $clog2(WARM_CYC + 1);

  logic [W-1:0] edge_w;
  logic [CW-1:0] warm_q;
  logic          armed;

  for (genvar b = 0; b < W; b++) begin : g_line
    logic s1_q, s2_q, hist_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        hist_q <= 1'b0;
      end else begin
        s1_q   <= lvl_i[b];
        s2_q   <= s1_q;
        hist_q <= s2_q;
      end
    end
    assign lvl_o[b]  = s2_q;
    assign edge_w[b] = (s2_q ^ hist_q) & mask_i[b];
  end

  // history fills from the synchronizer before edges are trusted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     warm_q <= '0;
    else if (!armed) warm_q <= warm_q + 1'b1;
  end

  assign armed = (warm_q == CW'(WARM_CYC));
  assign chg_o = armed & (|edge_w);

endmodule

// File: rtl/dbk_pending.sv
module dbk_pending (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chg_i,
  input  logic take_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q & ~take_i) | chg_i;
  end

  assign pend_o = pend_q;

  // R8
  chg_sets_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_i |=> pend_o);

  // R8
  take_clears_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !chg_i) |=> !pend_o);

endmodule

// File: rtl/dbk_arb.sv
module dbk_arb #(
  parameter int unsigned N_OTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dbk_req_i,
  input  logic             dbk_done_i,
  input  logic [N_OTH-1:0] oth_req_i,
  input  logic [N_OTH-1:0] oth_done_i,
  output logic             dbk_own_o,
  output logic [N_OTH-1:0] oth_own_o,
  output logic             bus_req_no
);
  import dbk_pkg::*;

  localparam int unsigned IW = (N_OTH > 1) ? $clog2(N_OTH) : 1;

  arb_state_e    state_q, state_d;
  logic [IW-1:0] idx_q, idx_d, pick;
  logic          oth_any;

  always_comb begin
    oth_any = |oth_req_i;
    pick    = '0;
    for (int i = N_OTH - 1; i >= 0; i--) begin
      if (oth_req_i[i]) pick = IW'(i);
    end
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ARB_IDLE: begin
        if (dbk_req_i) begin
          state_d = ARB_DBK;
        end else if (oth_any) begin
          state_d = ARB_OTH;
          idx_d   = pick;
        end
      end
      ARB_DBK: if (dbk_done_i) state_d = ARB_IDLE;
      ARB_OTH: if (oth_done_i[idx_q]) state_d = ARB_IDLE;
      default: state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ARB_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign dbk_own_o  = (state_q == ARB_DBK);
  assign bus_req_no = (state_q == ARB_IDLE);

  for (genvar i = 0; i < N_OTH; i++) begin : g_own
    assign oth_own_o[i] = (state_q == ARB_OTH) && (idx_q == IW'(i));

    // R4
    oth_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (oth_own_o[i] && !oth_done_i[i]) |=> oth_own_o[i]);
  end

  // R3
  dbk_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_no && dbk_req_i) |=> dbk_own_o);

  // R4
  dbk_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ARB_OTH) && oth_done_i[idx_q] && dbk_req_i) |=> ##1 dbk_own_o);

  // R5
  gap_after_dbk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbk_own_o && dbk_done_i) |=> bus_req_no);

endmodule

// File: rtl/dbk_wr_master.sv
module dbk_wr_master #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SNAP_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              own_i,
  input  logic              bus_gnt_ni,
  input  logic [SNAP_W-1:0] snap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              done_i,
  output logic              take_o,
  output logic              fin_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int unsigned PAD_W = DATA_W - SNAP_W;

  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign take_o = own_i & ~busy_q & ~bus_gnt_ni;
  assign fin_o  = busy_q & done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (take_o) begin
        busy_q <= 1'b1;
        addr_q <= addr_i;
        data_q <= {{PAD_W{1'b0}}, snap_i};
      end else if (fin_o) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign wr_valid_o = busy_q;
  assign wr_addr_o  = addr_q;
  assign wr_data_o  = data_q;

  // R6
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !done_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  // R6
  wr_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> own_i);

endmodule

// File: rtl/dbk_top.sv
module dbk_top #(
  parameter int unsigned IRQ_W  = 16,
  parameter int unsigned N_OTH  = 2,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IRQ_W-1:0]  irq_i,
  input  logic              smi_i,
  input  logic              smi_en_i,
  input  logic [ADDR_W-1:0] dbk_addr_i,
  input  logic [N_OTH-1:0]  oth_req_i,
  input  logic [N_OTH-1:0]  oth_done_i,
  output logic [N_OTH-1:0]  oth_own_o,
  output logic              bus_req_no,
  input  logic              bus_gnt_ni,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_done_i
);
  localparam int unsigned SNAP_W = IRQ_W + 1;

  logic [SNAP_W-1:0] snap;
  logic [SNAP_W-1:0] mask;
  logic              chg, pend, take, fin, dbk_own;

  assign mask = {smi_en_i, {IRQ_W{1'b1}}};

  dbk_edge_mon #(.W(SNAP_W)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({smi_i, irq_i}),
    .mask_i (mask),
    .lvl_o  (snap),
    .chg_o  (chg)
  );

  dbk_pending u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .chg_i  (chg),
    .take_i (take),
    .pend_o (pend)
  );

  dbk_arb #(.N_OTH(N_OTH)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dbk_req_i  (pend),
    .dbk_done_i (fin),
    .oth_req_i  (oth_req_i),
    .oth_done_i (oth_done_i),
    .dbk_own_o  (dbk_own),
    .oth_own_o  (oth_own_o),
    .bus_req_no (bus_req_no)
  );

  dbk_wr_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SNAP_W(SNAP_W)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .own_i      (dbk_own),
    .bus_gnt_ni (bus_gnt_ni),
    .snap_i     (snap),
    .addr_i     (dbk_addr_i),
    .done_i     (wr_done_i),
    .take_o     (take),
    .fin_o      (fin),
    .wr_valid_o (wr_valid_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o)
  );

  // R6
  valid_needs_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> !bus_req_no);

  // R9
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (bus_req_no && !wr_valid_o));

endmodule

// File: tb/dbk_top_tb_top.sv
module dbk_top_tb_top;
  localparam int IRQ_W = 16;
  localparam int N_OTH = 2;
  localparam int OHOLD = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n    = 1'b0;
  logic [IRQ_W-1:0]  irq      = 16'h00F0;
  logic              smi      = 1'b0;
  logic              smi_en   = 1'b0;
  logic [31:0]       addr     = 32'hFEE0_0040;
  logic [N_OTH-1:0]  oth_req  = '0;
  logic [N_OTH-1:0]  oth_done = '0;
  logic [N_OTH-1:0]  oth_own;
  logic              req_n;
  logic              gnt_n    = 1'b1;
  logic              wvalid;
  logic              wdone    = 1'b0;
  logic [31:0]       waddr, wdata;

  dbk_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .smi_i(smi), .smi_en_i(smi_en),
    .dbk_addr_i(addr), .oth_req_i(oth_req), .oth_done_i(oth_done),
    .oth_own_o(oth_own), .bus_req_no(req_n), .bus_gnt_ni(gnt_n),
    .wr_valid_o(wvalid), .wr_addr_o(waddr), .wr_data_o(wdata), .wr_done_i(wdone)
  );

  int vec = 0, miss = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
    end
  endtask

  // host: grant follows request, completion after hold_len cycles of valid
  int hold_len = 2;
  int hcnt = 0;
  always @(negedge clk) begin
    gnt_n = req_n;
    if (wvalid) begin
      hcnt++;
      wdone = (hcnt == hold_len);
    end else begin
      hcnt  = 0;
      wdone = 1'b0;
    end
  end

  // other requesters: kick raises a bid, tenure lasts OHOLD cycles
  int kick[N_OTH];
  int served[N_OTH];
  int ocnt[N_OTH];
  initial for (int i = 0; i < N_OTH; i++) begin kick[i] = 0; served[i] = 0; ocnt[i] = 0; end
  always @(negedge clk) begin
    for (int i = 0; i < N_OTH; i++) begin
      oth_done[i] = 1'b0;
      if (oth_own[i]) begin
        ocnt[i]++;
        if (ocnt[i] == OHOLD) begin
          oth_done[i] = 1'b1;
          served[i]++;
          ocnt[i] = 0;
        end
      end
      oth_req[i] = (kick[i] != served[i]);
    end
  end

  // behavioural reference, updated at each edge from pre-edge inputs
  logic [16:0] m_s [$];
  int          m_warm = 0, m_own = 0, m_oidx = 0;
  bit          m_pend = 0, m_busy = 0;
  logic [31:0] m_addr = '0, m_data = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s = {17'h0, 17'h0, 17'h0};
      m_warm = 0; m_own = 0; m_oidx = 0; m_pend = 0; m_busy = 0;
      m_addr = '0; m_data = '0;
    end else begin
      bit chg, take, fin;
      int nown, nidx;
      logic [16:0] mask;
      mask = {smi_en, 16'hFFFF};
      chg  = (m_warm >= 3) && (((m_s[1] ^ m_s[2]) & mask) != 0);
      take = (m_own == 1) && !m_busy && !gnt_n;
      fin  = m_busy && wdone;
      nown = m_own; nidx = m_oidx;
      if (m_own == 0) begin
        if (m_pend) nown = 1;
        else if (oth_req != 0) begin
          nown = 2;
          for (int i = N_OTH - 1; i >= 0; i--) if (oth_req[i]) nidx = i;
        end
      end else if (m_own == 1) begin
        if (fin) nown = 0;
      end else if (oth_done[m_oidx]) nown = 0;
      if (take) begin
        m_data = {15'h0, m_s[1]};
        m_addr = addr;
      end
      m_busy = m_busy ? !wdone : take;
      m_pend = (m_pend && !take) || chg;
      m_own = nown; m_oidx = nidx;
      void'(m_s.pop_back());
      m_s.push_front({smi, irq});
      if (m_warm < 3) m_warm++;
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    logic [N_OTH-1:0] eo;
    eo = (m_own == 2) ? N_OTH'(1 << m_oidx) : '0;
    chk(req_n === (m_own == 0), "R5 bus_req_no", 32'(req_n), 32'(m_own == 0));
    chk(oth_own === eo, "R4 oth_own", 32'(oth_own), 32'(eo));
    chk(wvalid === m_busy, "R6 wr_valid", 32'(wvalid), 32'(m_busy));
    if (m_busy) begin
      chk(waddr === m_addr, "R6 wr_addr", waddr, m_addr);
      chk(wdata === m_data, "R7 wr_data", wdata, m_data);
    end
  end

  // write and ownership log
  int          wr_cnt = 0;
  logic [31:0] last_data = '0;
  int          log_q[$];
  bit          pv = 0;
  logic [N_OTH-1:0] po = '0;
  always @(negedge clk) begin
    if (wvalid && !pv) begin
      wr_cnt++;
      last_data = wdata;
      log_q.push_back(9);
    end
    for (int i = 0; i < N_OTH; i++) if (oth_own[i] && !po[i]) log_q.push_back(i);
    pv = wvalid;
    po = oth_own;
  end

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_valid();
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (wvalid) break;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    miss++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    // R9: reset state with non-zero levels held
    repeat (3) @(negedge clk);
    chk(req_n === 1'b1, "R9 req in reset", 32'(req_n), 32'd1);
    chk(wvalid === 1'b0, "R9 valid in reset", 32'(wvalid), 32'd0);
    @(negedge clk) rst_n = 1'b1;
    settle(12);
    chk(wr_cnt == 0, "R9 no write after reset", wr_cnt, 0);
    chk(req_n === 1'b1, "R9 pin idle after reset", 32'(req_n), 32'd1);

    // R1: rising edge
    @(negedge clk) irq[3] = 1'b1;
    settle(20);
    chk(wr_cnt == 1, "R1 rising edge writes", wr_cnt, 1);
    chk(last_data == 32'h0000_00F8, "R7 rising data", last_data, 32'h0000_00F8);

    // R1: falling edge
    @(negedge clk) irq[7] = 1'b0;
    settle(20);
    chk(wr_cnt == 2, "R1 falling edge writes", wr_cnt, 2);
    chk(last_data == 32'h0000_0078, "R7 falling data", last_data, 32'h0000_0078);

    // R1: many lines at once give one write
    @(negedge clk) irq = 16'hA5A5;
    settle(20);
    chk(wr_cnt == 3, "R1 multi-line single write", wr_cnt, 3);
    chk(last_data == 32'h0000_A5A5, "R7 multi data", last_data, 32'h0000_A5A5);

    // R2: disabled event is dropped
    @(negedge clk) smi = 1'b1;
    settle(20);
    chk(wr_cnt == 3, "R2 disabled smi ignored", wr_cnt, 3);
    chk(req_n === 1'b1, "R2 pin idle", 32'(req_n), 32'd1);

    // R2: enabled event triggers
    @(negedge clk) begin smi_en = 1'b1; smi = 1'b0; end
    settle(20);
    chk(wr_cnt == 4, "R2 enabled smi writes", wr_cnt, 4);
    chk(last_data == 32'h0000_A5A5, "R7 smi low data", last_data, 32'h0000_A5A5);
    @(negedge clk) smi = 1'b1;
    settle(20);
    chk(wr_cnt == 5, "R2 enabled smi rise", wr_cnt, 5);
    chk(last_data == 32'h0001_A5A5, "R7 bit16 smi", last_data, 32'h0001_A5A5);

    // R8: edge during a write in flight
    hold_len = 6;
    @(negedge clk) irq[0] = 1'b0;
    wait_valid();
    irq[1] = 1'b1;
    settle(40);
    chk(wr_cnt == 7, "R8 one more write", wr_cnt, 7);
    chk(last_data == 32'h0001_A5A6, "R8 second data", last_data, 32'h0001_A5A6);

    // R4: holder not preempted, driveback next ahead of waiting requester
    hold_len = 2;
    log_q.delete();
    @(negedge clk) begin kick[1]++; irq[15] = 1'b0; end
    settle(3);
    @(negedge clk) kick[0]++;
    settle(60);
    chk(log_q.size() == 3, "R4 tenure count", log_q.size(), 3);
    if (log_q.size() == 3) begin
      chk(log_q[0] == 1, "R4 holder first", log_q[0], 1);
      chk(log_q[1] == 9, "R4 driveback next", log_q[1], 9);
      chk(log_q[2] == 0, "R4 waiting last", log_q[2], 0);
    end
    chk(wr_cnt == 8, "R4 write count", wr_cnt, 8);

    // R3: driveback beats a queued requester from idle
    hold_len = 8;
    log_q.delete();
    @(negedge clk) irq[14] = 1'b1;
    wait_valid();
    kick[0]++;
    irq[13] = 1'b0;
    settle(60);
    chk(log_q.size() == 3, "R3 tenure count", log_q.size(), 3);
    if (log_q.size() == 3) begin
      chk(log_q[0] == 9, "R3 first write", log_q[0], 9);
      chk(log_q[1] == 9, "R3 driveback wins", log_q[1], 9);
      chk(log_q[2] == 0, "R3 other after", log_q[2], 0);
    end
    chk(last_data == 32'h0001_45A6, "R7 final data", last_data, 32'h0001_45A6);

    // R6: address follows configuration
    hold_len = 2;
    @(negedge clk) begin addr = 32'h0000_0C10; irq[2] = 1'b0; end
    wait_valid();
    chk(waddr == 32'h0000_0C10, "R6 address", waddr, 32'h0000_0C10);
    settle(20);

    summary();
    $finish;
  end

endmodule